// File: doc/BRIEF.md
# Two-Level Lookahead Adder

This block adds two 16-bit operands and a carry input. It does not let the carry ripple from bit to bit. Each 4-bit slice works out all of its internal carries at once, from per-bit generate and propagate terms and the carry that enters the slice. Each slice also reduces its four bit pairs to one slice-generate term and one slice-propagate term. A second lookahead level takes these slice terms and the carry input. It produces the carry into every slice as a fully expanded sum of products, so no slice carry is formed from the carry of the slice below it.

The result is captured in one output register stage that has a synchronous active-high reset. Besides the sum and the carry out, the block presents the word-level generate and propagate terms. A wider adder can then treat this block as one group of its own lookahead tree. The slice width and the slice count are parameters, and the defaults give 16 bits.

Top module: `gcla_adder`

## Requirements
- R1: On the first rising clock edge after `x_in`, `y_in` and `c_in` are applied with `rst` low, `sum_out` takes (x_in + y_in + c_in) modulo 2^16 and holds it until the next edge.
- R2: On that same edge, `carry_out` takes bit 16 of the full 17-bit value x_in + y_in + c_in.
- R3: `word_gen` is 1 exactly when x_in + y_in alone, with no carry input, reaches 2^16 or more.
- R4: `word_prop` is 1 exactly when every one of the 16 bit positions has at least one operand bit set, that is when (x_in | y_in) equals 16'hFFFF.
- R5: `carry_out` equals `word_gen` OR (`word_prop` AND the registered `c_in`). The carry input can set the carry out only when `word_prop` is 1.
- R6: A rising edge with `rst` high clears `sum_out`, `carry_out`, `word_gen` and `word_prop` to 0, whatever the operands are.
- R7: All ones plus one wraps correctly. 16'hFFFF + 16'h0001 with c_in=0 gives sum 0 and carry_out 1. 16'hFFFF + 0 with c_in=1 gives the same, with word_gen 0 and word_prop 1.
- R8: A carry born in a lower slice crosses every slice boundary above it. Examples are 16'h000F+1 → 16'h0010, 16'h0FFF+1 → 16'h1000, and 16'hAAAA+16'h5555 with c_in=1 → sum 0 and carry_out 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all outputs update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| x_in | input | 16 | First operand |
| y_in | input | 16 | Second operand |
| c_in | input | 1 | Carry input into bit 0 |
| sum_out | output | 16 | Registered sum |
| carry_out | output | 1 | Registered carry out of bit 15 |
| word_gen | output | 1 | Registered word-level generate term |
| word_prop | output | 1 | Registered word-level propagate term |

## Verification
Every output is due exactly one rising edge after its operands are presented, because a single register stage sits between the lookahead logic and the pins. The bench drives operands on the falling edge and lets the next rising edge capture them. It compares all four outputs on the falling edge that follows. At that point it uses a reference built from plain integer arithmetic on the same operands. Reset is checked the same way: operands are held during reset, and zeros are expected one edge later.

// File: rtl/gcla_pkg.sv
package gcla_pkg;
  localparam int DEF_SLICE_W = 4;
  localparam int DEF_SLICES  = 4;
endpackage

// File: rtl/gcla_lookahead.sv
// Generic lookahead unit: fully expanded carries from generate/propagate
// terms and a carry input, plus the reduced generate/propagate of the span.
module gcla_lookahead #(
  parameter int N = 4
) (
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prop_i,
  input  logic         cin_i,
  output logic [N-2:0] cmid_o,   // cmid_o[k] = carry into position k+1
  output logic         span_gen_o,
  output logic         span_prop_o
);
  always_comb begin
    logic acc;
    logic prod;
    for (int k = 0; k < N - 1; k++) begin
      acc = 1'b0;
      for (int j = 0; j <= k; j++) begin
        prod = gen_i[j];
        for (int m = j + 1; m <= k; m++) prod = prod & prop_i[m];
        acc = acc | prod;
      end
      prod = cin_i;
      for (int m = 0; m <= k; m++) prod = prod & prop_i[m];
      cmid_o[k] = acc | prod;
    end
  end

  always_comb begin
    logic acc;
    logic prod;
    acc = 1'b0;
    for (int j = 0; j < N; j++) begin
      prod = gen_i[j];
      for (int m = j + 1; m < N; m++) prod = prod & prop_i[m];
      acc = acc | prod;
    end
    span_gen_o = acc;
  end

  assign span_prop_o = &prop_i;
endmodule

// File: rtl/gcla_slice.sv
// One lookahead slice: per-bit terms, internal carries, sum bits.
module gcla_slice #(
  parameter int W = 4
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         slice_gen_o,
  output logic         slice_prop_o
);
  logic [W-1:0] bit_gen;
  logic [W-1:0] bit_prop;
  logic [W-2:0] cmid;
  logic [W-1:0] cbit;

  assign bit_gen  = x_i & y_i;
  assign bit_prop = x_i | y_i;

  gcla_lookahead #(.N(W)) u_la (
    .gen_i      (bit_gen),
    .prop_i     (bit_prop),
    .cin_i      (cin_i),
    .cmid_o     (cmid),
    .span_gen_o (slice_gen_o),
    .span_prop_o(slice_prop_o)
  );

  assign cbit  = {cmid, cin_i};
  // OR-form propagate cannot form the sum; use the true half-sum
  assign sum_o = x_i ^ y_i ^ cbit;
endmodule

// File: rtl/gcla_adder.sv
module gcla_adder
  import gcla_pkg::*;
#(
  parameter int SLICE_W = DEF_SLICE_W,
  parameter int SLICES  = DEF_SLICES
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [SLICE_W*SLICES-1:0]  x_in,
  input  logic [SLICE_W*SLICES-1:0]  y_in,
  input  logic                       c_in,
  output logic [SLICE_W*SLICES-1:0]  sum_out,
  output logic                       carry_out,
  output logic                       word_gen,
  output logic                       word_prop
);
  localparam int WIDTH = SLICE_W * SLICES;

  logic [SLICES-1:0] sl_gen;
  logic [SLICES-1:0] sl_prop;
  logic [SLICES-2:0] sl_cmid;
  logic [SLICES-1:0] sl_cin;
  logic [WIDTH-1:0]  sum_c;
  logic              top_gen;
  logic              top_prop;
  logic              cout_c;

  // Second level: carries into each slice, fully expanded from slice terms
  gcla_lookahead #(.N(SLICES)) u_top_la (
    .gen_i      (sl_gen),
    .prop_i     (sl_prop),
    .cin_i      (c_in),
    .cmid_o     (sl_cmid),
    .span_gen_o (top_gen),
    .span_prop_o(top_prop)
  );

  assign sl_cin = {sl_cmid, c_in};
  assign cout_c = top_gen | (top_prop & c_in);

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    gcla_slice #(.W(SLICE_W)) u_slice (
      .x_i         (x_in[s*SLICE_W +: SLICE_W]),
      .y_i         (y_in[s*SLICE_W +: SLICE_W]),
      .cin_i       (sl_cin[s]),
      .sum_o       (sum_c[s*SLICE_W +: SLICE_W]),
      .slice_gen_o (sl_gen[s]),
      .slice_prop_o(sl_prop[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_out   <= '0;
      carry_out <= 1'b0;
      word_gen  <= 1'b0;
      word_prop <= 1'b0;
    end else begin
      sum_out   <= sum_c;
      carry_out <= cout_c;
      word_gen  <= top_gen;
      word_prop <= top_prop;
    end
  end

  // R1 R2
  sum_value_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ({carry_out, sum_out} ==
      ({1'b0, $past(x_in)} + {1'b0, $past(y_in)} + {{WIDTH{1'b0}}, $past(c_in)})));

  // R5
  gen_forces_carry_chk: assert property (@(posedge clk) disable iff (rst)
    word_gen |-> carry_out);

  // R5
  prop_passes_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && word_prop && !word_gen) |-> (carry_out == $past(c_in)));

  // R5
  kill_blocks_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (!word_gen && !word_prop) |-> !carry_out);

  // R6
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (sum_out == '0 && !carry_out && !word_gen && !word_prop));
endmodule

// File: tb/gcla_adder_test.sv
module gcla_adder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] x_in = '0;
  logic [15:0] y_in = '0;
  logic        c_in = 1'b0;
  logic [15:0] sum_out;
  logic        carry_out;
  logic        word_gen;
  logic        word_prop;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  gcla_adder uut (
    .clk(clk), .rst(rst), .x_in(x_in), .y_in(y_in), .c_in(c_in),
    .sum_out(sum_out), .carry_out(carry_out),
    .word_gen(word_gen), .word_prop(word_prop)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // apply operands on a falling edge, capture on the rising, compare on the next falling
  task automatic apply(input logic [15:0] a, input logic [15:0] b,
                       input logic c, input string req);
    int unsigned full;
    int unsigned gsum;
    x_in = a; y_in = b; c_in = c;
    full = int'(a) + int'(b) + int'(c);
    gsum = int'(a) + int'(b);
    @(posedge clk);
    @(negedge clk);
    chk({req, " R1"}, "sum", 32'(sum_out), full & 32'hFFFF);
    chk({req, " R2"}, "carry_out", 32'(carry_out), (full >> 16) & 1);
    chk({req, " R3"}, "word_gen", 32'(word_gen), 32'(gsum >= 32'h10000));
    chk({req, " R4"}, "word_prop", 32'(word_prop), 32'((a | b) == 16'hFFFF));
    chk({req, " R5"}, "carry_relation", 32'(carry_out),
        32'(((gsum >= 32'h10000) ? 1 : 0) | (((a | b) == 16'hFFFF) && c)));
  endtask

  initial begin
    // R6 reset with busy operands
    x_in = 16'hFFFF; y_in = 16'hFFFF; c_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R6", "sum", 32'(sum_out), 0);
    chk("R6", "carry_out", 32'(carry_out), 0);
    chk("R6", "word_gen", 32'(word_gen), 0);
    chk("R6", "word_prop", 32'(word_prop), 0);
    rst = 1'b0;

    apply(16'h0000, 16'h0000, 1'b0, "zero");
    apply(16'hFFFF, 16'h0001, 1'b0, "R7");
    apply(16'hFFFF, 16'h0000, 1'b1, "R7");
    apply(16'hFFFF, 16'hFFFF, 1'b1, "R7");
    apply(16'h000F, 16'h0001, 1'b0, "R8");
    apply(16'h0FFF, 16'h0001, 1'b0, "R8");
    apply(16'h00FF, 16'h0000, 1'b1, "R8");
    apply(16'hAAAA, 16'h5555, 1'b1, "R8");
    apply(16'hAAAA, 16'h5555, 1'b0, "R8");
    apply(16'h8000, 16'h8000, 1'b0, "R3");
    apply(16'hF0F0, 16'h0F0F, 1'b0, "R4");

    for (int i = 0; i < 400; i++)
      apply(16'($urandom), 16'($urandom), 1'($urandom), "rand");

    // R6 reset mid-run clears outputs
    x_in = 16'h1234; y_in = 16'hFFFF; c_in = 1'b1;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R6", "sum_mid", 32'(sum_out), 0);
    chk("R6", "carry_mid", 32'(carry_out), 0);
    rst = 1'b0;
    apply(16'h1234, 16'hEDCC, 1'b0, "R7");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule